// File: doc/BRIEF.md
# PCI Data Parity Response Checker

This block is a passive bus monitor. It watches the address/data lines, the byte-enable/command lines and the handshake signals of a PCI bus, which may be 32 or 64 bits wide. For every address phase and every completed data phase, it works out the even parity that the driving agent should put on the parity lines one clock later. It then compares that value with what actually shows up on `par` and `par64`. The lower 32-bit half and the upper 32-bit half are checked on their own, and the upper half is checked only on transfers where both sides agreed to run 64 bits wide.

When a data phase carries a parity error, the receiving agent must report it on PERR#. The monitor looks at `perr_n` exactly two clocks after that data phase, and it raises a separate flag for each half when the report is missing. Address-phase parity errors are only flagged as parity errors, because PERR# does not cover them. Every flag is sticky. A flag stays set until the `clr` pulse or a synchronous reset, so a test environment can look at the flags at its leisure after a run.

Top module: `pci_par_monitor`

## Requirements
- R1: An address phase is a cycle in which `frame_n` is low and the cycle before it had both `frame_n` and `irdy_n` high. In the cycle after an address phase or a completed data phase, `par` must equal the XOR of `ad[31:0]` and `cbe_n[3:0]` from that phase. A mismatch sets `err_par_lo`, which reads 1 from the cycle after the `par` sample.
- R2: In the cycle after a completed 64-bit data phase, `par64` must equal the XOR of `ad[63:32]` and `cbe_n[7:4]` from that phase. A mismatch sets `err_par_hi` with the same timing as R1.
- R3: A data phase counts as 64-bit only when `req64_n` was low in the address phase of the transaction and `ack64_n` is low in that data phase. In every other phase, including address phases, `par64` has no effect on any flag.
- R4: A data phase is complete only in a cycle where `irdy_n`, `trdy_n` and `devsel_n` are all low. After idle cycles and wait cycles, `par` and `par64` are not checked.
- R5: If a data phase has a low-half parity error and `perr_n` is high two clocks after that data phase, `err_perr_lo` is set, and it reads 1 from the next cycle on. If `perr_n` is low at that point, the flag is not set.
- R6: If a 64-bit data phase has a high-half parity error and `perr_n` is high two clocks after it, `err_perr_hi` is set.
- R7: A parity error in an address phase never causes a missing-report flag, whatever `perr_n` does.
- R8: All four flags are sticky. A cycle with `clr` high clears them at the next edge. A flag event that reaches the same edge as `clr` wins, so the flag stays set.
- R9: A synchronous reset (`rst` high at an edge) clears all flags and empties the pipeline. A phase that is still in flight when reset arrives raises no flag afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears the sticky error flags |
| ad | input | 64 | Address/data lines |
| cbe_n | input | 8 | Command / byte-enable lines, active low |
| par | input | 1 | Parity for the lower half |
| par64 | input | 1 | Parity for the upper half |
| perr_n | input | 1 | Data parity error report, active low |
| frame_n | input | 1 | Transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| req64_n | input | 1 | 64-bit transfer request, active low |
| ack64_n | input | 1 | 64-bit transfer acknowledge, active low |
| err_par_lo | output | 1 | Sticky lower-half parity mismatch |
| err_par_hi | output | 1 | Sticky upper-half parity mismatch |
| err_perr_lo | output | 1 | Sticky missing report for a lower-half error |
| err_perr_hi | output | 1 | Sticky missing report for an upper-half error |

## Verification
The bench targets several corner cases:
- Wrong `par` values placed right after wait cycles, including cycles where `irdy_n` and `trdy_n` are low but `devsel_n` is high. A design that treated these as data phases would raise false parity flags.
- Upper-half corruption on transfers where only one of `req64_n`/`ack64_n` is asserted. A monitor that ignored the handshake would set `err_par_hi` here.
- A corrupted address phase. A monitor that asked for PERR# on it would set `err_perr_lo`.
- A clear that lands on the same edge as a new mismatch. A design that gave the clear priority would lose the event.
- A reset that arrives while a corrupted data phase is still in the pipeline. A design whose pipeline survived reset would later report a missing PERR#.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int unsigned NHALF = 2;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // One captured phase waiting for its parity sample
  typedef struct packed {
    logic             valid;
    logic             is_data;
    logic             hi_en;
    logic [NHALF-1:0] exp;
  } par_stage_t;
endpackage

// File: rtl/pci_par_phase.sv
module pci_par_phase
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   frame_n,
  input  logic   irdy_n,
  input  logic   trdy_n,
  input  logic   devsel_n,
  input  logic   req64_n,
  input  logic   ack64_n,
  output phase_e ph,
  output logic   hi_en
);
  logic idle_q;
  logic wide_q;

  // Bus idle in the previous cycle marks the next frame_n low as an address phase
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      idle_q <= frame_n & irdy_n;
      if (ph == PH_ADDR) wide_q <= ~req64_n;
    end
  end

  always_comb begin
    ph = PH_NONE;
    if (!frame_n && idle_q)                 ph = PH_ADDR;
    else if (!irdy_n && !trdy_n && !devsel_n) ph = PH_DATA;
  end

  // Upper half counts only when both sides agreed on a wide transfer
  assign hi_en = (ph == PH_DATA) && wide_q && !ack64_n;
endmodule

// File: rtl/pci_par_half.sv
module pci_par_half #(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 4
) (
  input  logic [DW-1:0] ad,
  input  logic [BW-1:0] be,
  output logic          par
);
  // Even parity: the parity bit makes the total count of ones even
  assign par = ^{ad, be};
endmodule

// File: rtl/pci_par_pipe.sv
module pci_par_pipe
  import pci_par_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  phase_e           ph,
  input  logic             hi_en,
  input  logic [NHALF-1:0] exp_par,
  input  logic [NHALF-1:0] par_in,
  output logic [NHALF-1:0] mism,
  output logic [NHALF-1:0] due,
  output logic             s1_valid,
  output logic             s1_hi
);
  par_stage_t       s1_q;
  logic [NHALF-1:0] due_d;
  logic [NHALF-1:0] due_q;

  // Stage 1: hold the phase one cycle, until its parity arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
    end else begin
      s1_q.valid   <= (ph != PH_NONE);
      s1_q.is_data <= (ph == PH_DATA);
      s1_q.hi_en   <= hi_en;
      s1_q.exp     <= exp_par;
    end
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_cmp
    logic en;
    if (h == 0) begin : g_base
      assign en = 1'b1;
    end else begin : g_wide
      assign en = s1_q.hi_en;
    end
    assign mism[h]  = s1_q.valid && en && (par_in[h] != s1_q.exp[h]);
    assign due_d[h] = mism[h] && s1_q.is_data;
  end

  // Stage 2: data-phase errors wait here for the PERR# sample
  always_ff @(posedge clk) begin
    if (rst) due_q <= '0;
    else     due_q <= due_d;
  end

  assign due      = due_q;
  assign s1_valid = s1_q.valid;
  assign s1_hi    = s1_q.hi_en;
endmodule

// File: rtl/pci_par_flags.sv
module pci_par_flags
  import pci_par_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             perr_n,
  input  logic [NHALF-1:0] mism,
  input  logic [NHALF-1:0] due,
  output logic [NHALF-1:0] err_par,
  output logic [NHALF-1:0] err_perr
);
  logic [NHALF-1:0] keep;

  assign keep = ~{NHALF{clr}};

  // A new event outranks a clear on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      err_par  <= '0;
      err_perr <= '0;
    end else begin
      err_par  <= (err_par & keep) | mism;
      err_perr <= (err_perr & keep) | (due & {NHALF{perr_n}});
    end
  end
endmodule

// File: rtl/pci_par_monitor.sv
module pci_par_monitor
  import pci_par_pkg::*;
#(
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned HALF_BE = 4,
  localparam int unsigned AD_W   = NHALF * HALF_W,
  localparam int unsigned BE_W   = NHALF * HALF_BE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            par,
  input  logic            par64,
  input  logic            perr_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            devsel_n,
  input  logic            req64_n,
  input  logic            ack64_n,
  output logic            err_par_lo,
  output logic            err_par_hi,
  output logic            err_perr_lo,
  output logic            err_perr_hi
);
  phase_e           ph;
  logic             hi_en;
  logic [NHALF-1:0] exp_par;
  logic [NHALF-1:0] mism;
  logic [NHALF-1:0] due;
  logic             s1_valid;
  logic             s1_hi;
  logic [NHALF-1:0] err_par_v;
  logic [NHALF-1:0] err_perr_v;

  pci_par_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .trdy_n   (trdy_n),
    .devsel_n (devsel_n),
    .req64_n  (req64_n),
    .ack64_n  (ack64_n),
    .ph       (ph),
    .hi_en    (hi_en)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_calc
    pci_par_half #(.DW(HALF_W), .BW(HALF_BE)) u_half (
      .ad  (ad[h*HALF_W +: HALF_W]),
      .be  (cbe_n[h*HALF_BE +: HALF_BE]),
      .par (exp_par[h])
    );
  end

  pci_par_pipe u_pipe (
    .clk      (clk),
    .rst      (rst),
    .ph       (ph),
    .hi_en    (hi_en),
    .exp_par  (exp_par),
    .par_in   ({par64, par}),
    .mism     (mism),
    .due      (due),
    .s1_valid (s1_valid),
    .s1_hi    (s1_hi)
  );

  pci_par_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .perr_n   (perr_n),
    .mism     (mism),
    .due      (due),
    .err_par  (err_par_v),
    .err_perr (err_perr_v)
  );

  assign err_par_lo  = err_par_v[0];
  assign err_par_hi  = err_par_v[1];
  assign err_perr_lo = err_perr_v[0];
  assign err_perr_hi = err_perr_v[1];
endmodule

// File: rtl/pci_par_monitor_chk.sv
module pci_par_monitor_chk
  import pci_par_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   clr,
  input logic   perr_n,
  input phase_e ph,
  input logic   s1_valid,
  input logic   s1_hi,
  input logic   due_lo,
  input logic   due_hi,
  input logic   err_par_lo,
  input logic   err_par_hi,
  input logic   err_perr_lo,
  input logic   err_perr_hi
);
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> !(err_par_lo || err_par_hi || err_perr_lo || err_perr_hi));

  p_sticky_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (err_par_lo && !clr) |=> err_par_lo);

  p_clear_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !s1_valid && !due_lo && !due_hi)
      |=> !(err_par_lo || err_par_hi || err_perr_lo || err_perr_hi));

  p_lo_after_phase_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(err_par_lo) |-> $past(ph != PH_NONE, 2));

  p_hi_needs_wide_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(err_par_hi) |-> $past(s1_hi));

  p_perr_lo_missing_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(err_perr_lo) |-> ($past(perr_n) && $past(due_lo)));

  p_perr_hi_missing_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_perr_hi) |-> ($past(perr_n) && $past(due_hi)));
endmodule

bind pci_par_monitor pci_par_monitor_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr         (clr),
  .perr_n      (perr_n),
  .ph          (ph),
  .s1_valid    (s1_valid),
  .s1_hi       (s1_hi),
  .due_lo      (due[0]),
  .due_hi      (due[1]),
  .err_par_lo  (err_par_lo),
  .err_par_hi  (err_par_hi),
  .err_perr_lo (err_perr_lo),
  .err_perr_hi (err_perr_hi)
);

// File: tb/pci_par_monitor_tb_top.sv
module pci_par_monitor_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, clr = 1'b0;
  logic [63:0] ad = '0;
  logic [7:0]  cbe_n = '1;
  logic        par = 1'b0, par64 = 1'b0, perr_n = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1;
  logic        req64_n = 1'b1, ack64_n = 1'b1;
  logic        err_par_lo, err_par_hi, err_perr_lo, err_perr_hi;

  pci_par_monitor dut_i (
    .clk(clk), .rst(rst), .clr(clr), .ad(ad), .cbe_n(cbe_n), .par(par),
    .par64(par64), .perr_n(perr_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .req64_n(req64_n), .ack64_n(ack64_n),
    .err_par_lo(err_par_lo), .err_par_hi(err_par_hi),
    .err_perr_lo(err_perr_lo), .err_perr_hi(err_perr_hi)
  );

  int n_chk = 0, n_bad = 0;
  bit exp_plo, exp_phi, exp_mlo, exp_mhi;
  bit pend_v, pend_par, pend_par64;
  bit sched0 = 1'b1, sched1 = 1'b1;
  bit clr_pend, rst_pend;
  int k_addr, k_lo, k_hi, k_rep;

  function automatic bit evp(logic [31:0] a, logic [3:0] b);
    return ^{a, b};
  endfunction

  function automatic bit pct(int p);
    return int'($urandom % 100) < p;
  endfunction

  task automatic chk(string req, string name, bit got, bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, name, got, exp);
    end
  endtask

  task automatic chk_flags(string tlo, string thi, string tmlo, string tmhi);
    chk(tlo,  "err_par_lo",  err_par_lo,  exp_plo);
    chk(thi,  "err_par_hi",  err_par_hi,  exp_phi);
    chk(tmlo, "err_perr_lo", err_perr_lo, exp_mlo);
    chk(tmhi, "err_perr_hi", err_perr_hi, exp_mhi);
  endtask

  task automatic zero_exp();
    exp_plo = 0; exp_phi = 0; exp_mlo = 0; exp_mhi = 0;
  endtask

  // One bus cycle; parity and PERR# for earlier phases come from the schedule
  task automatic drive_cycle(bit f, bit i, bit t, bit d, bit r64n, bit a64n,
                             bit is_addr, bit is_data, bit hi_chk);
    bit fl_lo, fl_hi, rep;
    @(negedge clk);
    frame_n = f; irdy_n = i; trdy_n = t; devsel_n = d;
    req64_n = r64n; ack64_n = a64n;
    ad = {$urandom, $urandom};
    cbe_n = 8'($urandom);
    clr = clr_pend; clr_pend = 0;
    rst = rst_pend; rst_pend = 0;
    par   = pend_v ? pend_par   : 1'($urandom);
    par64 = pend_v ? pend_par64 : 1'($urandom);
    perr_n = sched0;
    sched0 = sched1;
    fl_lo = is_addr ? pct(k_addr) : (is_data ? pct(k_lo) : 1'b0);
    fl_hi = is_data ? pct(k_hi) : 1'b0;
    rep = pct(k_rep);
    pend_v = is_addr || is_data;
    pend_par   = evp(ad[31:0], cbe_n[3:0]) ^ fl_lo;
    pend_par64 = evp(ad[63:32], cbe_n[7:4]) ^ fl_hi;
    if (is_data && (fl_lo || (hi_chk && fl_hi))) sched1 = !rep;
    else sched1 = 1'($urandom);
    exp_plo |= fl_lo;
    exp_phi |= hi_chk & fl_hi;
    exp_mlo |= is_data & fl_lo & !rep;
    exp_mhi |= is_data & hi_chk & fl_hi & !rep;
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) drive_cycle(1, 1, 1, 1, 1, 1, 0, 0, 0);
  endtask

  task automatic txn(int nd, bit r64, bit a64);
    drive_cycle(0, 1, 1, 1, !r64, 1, 1, 0, 0);
    for (int k = 0; k < nd; k++) begin
      int w = int'($urandom % 3);
      for (int j = 0; j < w; j++) begin
        case ($urandom % 3)
          0: drive_cycle(0, 1, 0, 0, !r64, !a64, 0, 0, 0);
          1: drive_cycle(0, 0, 1, 0, !r64, !a64, 0, 0, 0);
          default: drive_cycle(0, 0, 0, 1, !r64, !a64, 0, 0, 0);
        endcase
      end
      drive_cycle(k == nd - 1, 0, 0, 0, !r64, !a64, 0, 1, r64 && a64);
    end
    idle(4);
  endtask

  task automatic clear_and_check();
    clr_pend = 1;
    idle(2);
    zero_exp();
    chk_flags("R8", "R8", "R8", "R8");
  endtask

  task automatic knobs(int a, int l, int h, int r);
    k_addr = a; k_lo = l; k_hi = h; k_rep = r;
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1CE5_0DD5));
    knobs(0, 0, 0, 0);
    zero_exp();
    rst_pend = 1; idle(1);
    rst_pend = 1; idle(1);
    idle(2);
    chk_flags("R9", "R9", "R9", "R9");            // reset state

    // R7: address-phase corruption flags parity only
    knobs(100, 0, 0, 0);
    txn(2, 0, 0);
    chk_flags("R7", "R7", "R7", "R7");
    clear_and_check();

    // R3: upper half ignored without both REQ64#/ACK64#
    knobs(0, 0, 100, 0);
    txn(3, 1, 0);
    chk_flags("R3", "R3", "R3", "R3");
    txn(3, 0, 1);
    chk_flags("R3", "R3", "R3", "R3");
    clear_and_check();

    // R2, R6: wide transfer, upper errors not reported
    knobs(0, 0, 100, 0);
    txn(2, 1, 1);
    chk_flags("R2", "R2", "R6", "R6");
    clear_and_check();

    // R5: lower errors not reported; then reported ones give no R5 flag
    knobs(0, 100, 0, 0);
    txn(2, 0, 0);
    chk_flags("R1", "R1", "R5", "R5");
    clear_and_check();
    knobs(0, 100, 100, 100);
    txn(3, 1, 1);
    chk_flags("R1", "R2", "R5", "R6");
    clear_and_check();

    // R4: clean phases, garbage parity after idle and wait cycles
    knobs(0, 0, 0, 0);
    for (int n = 0; n < 6; n++) txn(4, 1, 1);
    chk_flags("R4", "R4", "R4", "R4");

    // R8: mismatch and clear on the same edge; the event wins
    knobs(0, 100, 0, 100);
    drive_cycle(0, 1, 1, 1, 1, 1, 1, 0, 0);
    drive_cycle(1, 0, 0, 0, 1, 1, 0, 1, 0);
    clr_pend = 1;
    idle(5);
    chk_flags("R8", "R8", "R8", "R8");
    clear_and_check();

    // R9: reset while a bad unreported data phase is in flight
    knobs(0, 100, 0, 0);
    drive_cycle(0, 1, 1, 1, 1, 1, 1, 0, 0);
    drive_cycle(1, 0, 0, 0, 1, 1, 0, 1, 0);
    rst_pend = 1;
    idle(1);
    zero_exp();
    idle(5);
    chk_flags("R9", "R9", "R9", "R9");

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      knobs(8, 12, 12, 50);
      txn(1 + int'($urandom % 4), 1'($urandom), 1'($urandom));
      chk_flags("R1", "R2", "R5", "R6");
      if (($urandom % 2) == 0) clear_and_check();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule